// File: doc/BRIEF.md
# Bus-to-Device Handshake Controller

This block is the control sequencer between a system bus and one peripheral. The bus master opens a transfer by raising either its read strobe or its write strobe. The controller then runs a four-phase handshake toward the device through a device strobe and a device acknowledge. It opens the data transceiver at the point in the sequence that suits the transfer direction, and it answers the master with a bus acknowledge. Read and write follow different event orders. In a read, the transceiver opens after the device acknowledges and closes when the master lets go. In a write, the transceiver opens before the device strobe and closes once the device has taken the data.

All three handshake inputs are asynchronous to the controller clock. Each one passes through a synchronizer chain before the sequencer sees it. The outputs are registered, and a state change moves them on the same edge. The master alone chooses between a read and a write. If both strobes are seen together while idle, the controller refuses to start and raises a sticky error flag, which only reset clears.

Top module: `hsk_bridge_ctrl`

## Requirements
- R1: Read start: a read strobe seen while idle raises `dev_stb` alone. After `dev_ack` rises, `xcvr_en` rises while `dev_stb` stays high (vector 110). One cycle later `bus_ack` rises (vector 111). The output vector is {dev_stb, xcvr_en, bus_ack}.
- R2: Read end: after the read strobe falls, `xcvr_en` falls first (vector 101). One cycle later `bus_ack` and `dev_stb` fall on the same edge (vector 000).
- R3: Write start: a write strobe seen while idle raises `xcvr_en` alone (vector 010). One cycle later `dev_stb` rises (vector 110). After `dev_ack` rises, `xcvr_en` falls (vector 100). One cycle later `bus_ack` rises (vector 101).
- R4: Write end: after the write strobe falls, `bus_ack` and `dev_stb` fall on the same edge (vector 000). `xcvr_en` is already low.
- R5: Latency: with the default of two synchronizer stages, an output change caused by an input appears on the third rising clock edge after that input changes. Internal one-cycle steps take one edge. No edge changes more than two outputs.
- R6: No new `dev_stb` or `xcvr_en` rise happens while `dev_ack` from the previous transfer is still high. Once `dev_ack` falls, a pending strobe starts its transfer on the fourth edge.
- R7: If both strobes are high in the same sample while idle, the outputs stay low and `proto_err` rises on the third edge. It then stays high through later normal transfers until reset.
- R8: A synchronous active-low reset (`rst_n` low at a rising edge) drives all outputs, including `proto_err`, low on that edge. It also returns the controller to idle, even in the middle of a transfer.
- R9: `bus_ack` is never high while `dev_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_rd_stb | input | 1 | Bus read strobe, asynchronous |
| bus_wr_stb | input | 1 | Bus write strobe, asynchronous |
| dev_ack | input | 1 | Device acknowledge, asynchronous |
| dev_stb | output | 1 | Strobe toward the device |
| xcvr_en | output | 1 | Data transceiver enable |
| bus_ack | output | 1 | Data acknowledge to the bus master |
| proto_err | output | 1 | Sticky flag: both strobes seen together while idle |

## Verification
The hardest state to reach from the ports is the one where the master has already asked for a new transfer while the device still holds its acknowledge from the previous one. The controller must then wait, and it must not take the fresh strobe as a new start. The bench reaches this state on purpose. It completes a read, keeps the device acknowledge high, and raises the read strobe again at once. It then checks that the outputs stay quiet, and that the strobe answers exactly four edges after the acknowledge finally drops. Random device and master delays, including zero, are applied across table-driven and random transfers in both directions.

// File: rtl/hsk_pkg.sv
// Shared types for the bus-to-device handshake controller.
// Assumes: one controller state value per distinct output vector phase.
package hsk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_DATA,
        ST_RD_DONE,
        ST_RD_DROP,
        ST_WR_OPEN,
        ST_WR_REQ,
        ST_WR_CLOSE,
        ST_WR_DONE,
        ST_RELEASE
    } hsk_state_e;

    typedef struct packed {
        logic dev_stb;
        logic xcvr_en;
        logic bus_ack;
    } hsk_out_t;

    // Output vector owned by each state (Moore decode).
    function automatic hsk_out_t out_of(hsk_state_e s);
        hsk_out_t o;
        case (s)
            ST_RD_REQ:   o = '{dev_stb: 1'b1, xcvr_en: 1'b0, bus_ack: 1'b0};
            ST_RD_DATA:  o = '{dev_stb: 1'b1, xcvr_en: 1'b1, bus_ack: 1'b0};
            ST_RD_DONE:  o = '{dev_stb: 1'b1, xcvr_en: 1'b1, bus_ack: 1'b1};
            ST_RD_DROP:  o = '{dev_stb: 1'b1, xcvr_en: 1'b0, bus_ack: 1'b1};
            ST_WR_OPEN:  o = '{dev_stb: 1'b0, xcvr_en: 1'b1, bus_ack: 1'b0};
            ST_WR_REQ:   o = '{dev_stb: 1'b1, xcvr_en: 1'b1, bus_ack: 1'b0};
            ST_WR_CLOSE: o = '{dev_stb: 1'b1, xcvr_en: 1'b0, bus_ack: 1'b0};
            ST_WR_DONE:  o = '{dev_stb: 1'b1, xcvr_en: 1'b0, bus_ack: 1'b1};
            default:     o = '{dev_stb: 1'b0, xcvr_en: 1'b0, bus_ack: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/hsk_sync.sv
// Multi-stage synchronizer for a vector of independent asynchronous bits.
// Assumes: each bit is a level handshake signal, so per-bit skew of one
// cycle between bits is acceptable; STAGES is at least 2.
module hsk_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift each bit through the register chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/hsk_fsm.sv
// Handshake sequencer: orders device strobe, transceiver enable and bus
// acknowledge for read and write transfers, and keeps a sticky error flag.
// Assumes: inputs are already synchronized; outputs are registered from
// the next-state decode so they move on the same edge as the state.
module hsk_fsm
    import hsk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    input  logic ack_s,
    output logic dev_stb,
    output logic xcvr_en,
    output logic bus_ack,
    output logic proto_err
);

    hsk_state_e state_q, state_d;
    hsk_out_t   out_q;
    logic       err_q;
    logic       err_set;

    // Next-state selection for both transfer directions.
    always_comb begin
        state_d = state_q;
        err_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_s && wr_s) begin
                    err_set = 1'b1;
                end else if (!ack_s) begin
                    if (rd_s) begin
                        state_d = ST_RD_REQ;
                    end else if (wr_s) begin
                        state_d = ST_WR_OPEN;
                    end
                end
            end
            ST_RD_REQ:   if (ack_s) state_d = ST_RD_DATA;
            ST_RD_DATA:  state_d = ST_RD_DONE;
            ST_RD_DONE:  if (!rd_s) state_d = ST_RD_DROP;
            ST_RD_DROP:  state_d = ST_RELEASE;
            ST_WR_OPEN:  state_d = ST_WR_REQ;
            ST_WR_REQ:   if (ack_s) state_d = ST_WR_CLOSE;
            ST_WR_CLOSE: state_d = ST_WR_DONE;
            ST_WR_DONE:  if (!wr_s) state_d = ST_RELEASE;
            ST_RELEASE:  if (!ack_s) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State, registered outputs and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            out_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            out_q   <= out_of(state_d);
            if (err_set) begin
                err_q <= 1'b1;
            end
        end
    end

    assign dev_stb   = out_q.dev_stb;
    assign xcvr_en   = out_q.xcvr_en;
    assign bus_ack   = out_q.bus_ack;
    assign proto_err = err_q;

endmodule

// File: rtl/hsk_bridge_ctrl.sv
// Top of the bus-to-device handshake controller: synchronizes the three
// asynchronous handshake inputs and feeds them to the sequencer.
// Assumes: the bus never intends both strobes at once, and the device
// keeps its acknowledge high until it sees the device strobe fall.
module hsk_bridge_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rd_stb,
    input  logic bus_wr_stb,
    input  logic dev_ack,
    output logic dev_stb,
    output logic xcvr_en,
    output logic bus_ack,
    output logic proto_err
);

    localparam int N_IN   = 3;
    localparam int IX_RD  = 0;
    localparam int IX_WR  = 1;
    localparam int IX_ACK = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] sync_in;

    assign raw_in[IX_RD]  = bus_rd_stb;
    assign raw_in[IX_WR]  = bus_wr_stb;
    assign raw_in[IX_ACK] = dev_ack;

    hsk_sync #(
        .WIDTH (N_IN),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (sync_in)
    );

    hsk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_s     (sync_in[IX_RD]),
        .wr_s     (sync_in[IX_WR]),
        .ack_s    (sync_in[IX_ACK]),
        .dev_stb  (dev_stb),
        .xcvr_en  (xcvr_en),
        .bus_ack  (bus_ack),
        .proto_err(proto_err)
    );

endmodule

// File: rtl/hsk_bridge_ctrl_chk.sv
// Port-level protocol checker for hsk_bridge_ctrl, attached by bind.
// Assumes: default synchronizer depth (input seen one $past later than
// the sample that drives the next state).
module hsk_bridge_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_rd_stb,
    input logic bus_wr_stb,
    input logic dev_ack,
    input logic dev_stb,
    input logic xcvr_en,
    input logic bus_ack,
    input logic proto_err
);

    logic [2:0] outs;
    logic       rst_seen_q;

    assign outs = {dev_stb, xcvr_en, bus_ack};

    // Remember that the last edge sampled reset.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Outputs must be clear after a reset edge.
    always @(negedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clears_R8: assert (outs == 3'b000 && !proto_err);
        end
    end

    assert_ack_needs_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> dev_stb);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    assert_clash_holds_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (outs == 3'b000 && $past(bus_rd_stb) && $past(bus_wr_stb)) |=> (outs == 3'b000));

    assert_no_start_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (outs == 3'b000 && $past(dev_ack)) |=> (outs == 3'b000));

    assert_step_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(outs ^ $past(outs)) <= 2));

endmodule

bind hsk_bridge_ctrl hsk_bridge_ctrl_chk u_chk (.*);

// File: tb/tb_hsk_bridge_ctrl.sv
`timescale 1ns/1ps
module tb_hsk_bridge_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0;
    logic wr = 1'b0;
    logic ack = 1'b0;
    logic dev_stb, xcvr_en, bus_ack, proto_err;

    int checks = 0;
    int fails = 0;
    logic [2:0] last_out = 3'b000;

    hsk_bridge_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_rd_stb(rd), .bus_wr_stb(wr),
        .dev_ack(ack), .dev_stb(dev_stb), .xcvr_en(xcvr_en),
        .bus_ack(bus_ack), .proto_err(proto_err)
    );

    always #2 clk = ~clk;

    // Row: {first vector[15:13], is_write[12], dev delay[11:8], host delay[7:4], release delay[3:0]}
    localparam logic [15:0] VEC [0:7] = '{
        {3'b100, 1'b0, 4'd0, 4'd0, 4'd0},
        {3'b010, 1'b1, 4'd0, 4'd0, 4'd0},
        {3'b100, 1'b0, 4'd3, 4'd5, 4'd2},
        {3'b010, 1'b1, 4'd4, 4'd1, 4'd6},
        {3'b100, 1'b0, 4'd15, 4'd15, 4'd15},
        {3'b010, 1'b1, 4'd15, 4'd0, 4'd9},
        {3'b010, 1'b1, 4'd1, 4'd7, 4'd0},
        {3'b100, 1'b0, 4'd7, 4'd1, 4'd4}
    };

    function automatic logic [2:0] cur();
        return {dev_stb, xcvr_en, bus_ack};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for the next output change; check its value, timing and R9.
    task automatic step_expect(input logic [2:0] exp, input int ncyc, input string req);
        int n = 0;
        logic [2:0] now = last_out;
        while (now == last_out && n < 60) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            now = cur();
        end
        chk(now == exp, req, "outputs", int'(now), int'(exp));
        chk(n == ncyc, {req, ",R5"}, "cycles", n, ncyc);
        chk(!(now[0] && !now[2]), "R9", "ack_without_stb", int'(now), int'(exp));
        last_out = now;
    endtask

    task automatic hold_expect(input int n, input string req);
        cyc(n);
        chk(cur() == last_out, req, "held_outputs", int'(cur()), int'(last_out));
    endtask

    task automatic run_txn(input bit is_wr, input int dd, input int hd, input int rl,
                           input logic [2:0] first);
        if (!is_wr) begin
            rd = 1'b1;
            step_expect(first, 3, "R1");
            cyc(dd); ack = 1'b1;
            step_expect(3'b110, 3, "R1");
            step_expect(3'b111, 1, "R1");
            cyc(hd); rd = 1'b0;
            step_expect(3'b101, 3, "R2");
            step_expect(3'b000, 1, "R2");
            cyc(rl); ack = 1'b0;
            hold_expect(5, "R2");
        end else begin
            wr = 1'b1;
            step_expect(first, 3, "R3");
            step_expect(3'b110, 1, "R3");
            cyc(dd); ack = 1'b1;
            step_expect(3'b100, 3, "R3");
            step_expect(3'b101, 1, "R3");
            cyc(hd); wr = 1'b0;
            step_expect(3'b000, 3, "R4");
            cyc(rl); ack = 1'b0;
            hold_expect(5, "R4");
        end
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R8: reset state.
        cyc(3);
        chk(cur() == 3'b000, "R8", "reset_outputs", int'(cur()), 0);
        chk(!proto_err, "R8", "reset_err", int'(proto_err), 0);
        rst_n = 1'b1;
        cyc(2);

        // Table-driven transfers (R1-R5 by direction).
        for (int i = 0; i < 8; i++) begin
            run_txn(VEC[i][12], int'(VEC[i][11:8]), int'(VEC[i][7:4]),
                    int'(VEC[i][3:0]), VEC[i][15:13]);
        end

        // Random response delays in both directions.
        for (int i = 0; i < 16; i++) begin
            bit w = 1'($urandom_range(0, 1));
            run_txn(w, int'($urandom_range(0, 9)), int'($urandom_range(0, 9)),
                    int'($urandom_range(0, 9)), w ? 3'b010 : 3'b100);
        end

        // R6: new read request while the device still holds its acknowledge.
        rd = 1'b1;
        step_expect(3'b100, 3, "R1");
        ack = 1'b1;
        step_expect(3'b110, 3, "R1");
        step_expect(3'b111, 1, "R1");
        rd = 1'b0;
        step_expect(3'b101, 3, "R2");
        step_expect(3'b000, 1, "R2");
        rd = 1'b1;
        hold_expect(12, "R6");
        ack = 1'b0;
        step_expect(3'b100, 4, "R6");
        ack = 1'b1;
        step_expect(3'b110, 3, "R1");
        step_expect(3'b111, 1, "R1");
        rd = 1'b0;
        step_expect(3'b101, 3, "R2");
        step_expect(3'b000, 1, "R2");
        ack = 1'b0;
        cyc(6);

        // R7: both strobes in the same sample while idle.
        rd = 1'b1; wr = 1'b1;
        cyc(2);
        chk(!proto_err, "R7", "err_early", int'(proto_err), 0);
        cyc(1);
        chk(proto_err, "R7", "err_rise", int'(proto_err), 1);
        hold_expect(10, "R7");
        rd = 1'b0; wr = 1'b0;
        cyc(5);
        chk(proto_err, "R7", "err_sticky", int'(proto_err), 1);
        run_txn(1'b1, 2, 2, 2, 3'b010);
        chk(proto_err, "R7", "err_after_txn", int'(proto_err), 1);

        // R8: reset in the middle of a read.
        rd = 1'b1;
        step_expect(3'b100, 3, "R1");
        ack = 1'b1;
        step_expect(3'b110, 3, "R1");
        step_expect(3'b111, 1, "R1");
        rst_n = 1'b0;
        cyc(1);
        chk(cur() == 3'b000, "R8", "midreset_outputs", int'(cur()), 0);
        chk(!proto_err, "R8", "midreset_err", int'(proto_err), 0);
        rst_n = 1'b1; rd = 1'b0; ack = 1'b0;
        last_out = 3'b000;
        hold_expect(6, "R8");
        run_txn(1'b0, 1, 1, 1, 3'b100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule